// File: doc/BRIEF.md
# Speculative Register Checkpoint with Gated Store Buffer

This block lets a translated code block run speculatively and then either commit or roll back as one unit. Every architectural register exists twice: a working copy that execution reads and writes, and a shadow copy that holds the last committed state. Stores do not go to memory when they execute. They wait in a small gated buffer, and loads look up that buffer before they use memory data.

At the end of a block the execution engine pulses `commit`. That copies every working register into its shadow in one cycle and releases the buffered stores, which then drain to memory through a simple write port, one per cycle and oldest first. When an exception occurs the engine pulses `rollback` instead. Every working register then takes its shadow value again and all unreleased stores are dropped, so the machine state is precise at the block boundary. A register write can replace only the low byte of a register, and that partial update is speculative in the same way as a full write.

Top module: `spec_ckpt_core`

## Requirements
- R1: After a cycle with `rst_n` low, every working and shadow register reads 0, the buffer is empty, and `st_stall`, `drain_busy` and `mem_wr_en` are low.
- R2: A write with `wr_en` high updates the working register `wr_idx` at the clock edge; with `wr_part` high only bits 7:0 take `wr_data[7:0]` and bits 31:8 keep their value. `rd_data` shows working register `rd_idx` in the same cycle, without a clock edge.
- R3: A `commit` copies every working register into its shadow at that edge. A register write in the same cycle as `commit` is not part of the copy and stays speculative.
- R4: A `rollback` restores every working register from its shadow at that edge. It takes priority over a same-cycle register write and over a same-cycle `commit`.
- R5: An accepted store never drives `mem_wr_en` before a `commit` has released it.
- R6: A load on `ld_addr` returns, with `ld_hit` high, the data of the youngest held store whose full-word address equals `ld_addr`; with no match `ld_hit` is low and `ld_data` equals `ld_mem_data`. A store becomes visible to loads in the cycle after its acceptance.
- R7: After a commit, the released stores appear on `mem_wr_en`/`mem_wr_addr`/`mem_wr_data` one per cycle in the order they were accepted, the first in the cycle right after the commit edge. A store accepted in the commit cycle belongs to the next block.
- R8: `drain_busy` is high in exactly the cycles in which a released store is written, so it stays high for as many cycles as stores were released.
- R9: With 8 stores held, `st_stall` is high and a store offered then is dropped: it never forwards and never reaches memory.
- R10: A `rollback` drops every unreleased store, including one offered in the same cycle; stores already released by an earlier commit still drain to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_idx | input | 4 | Register read index |
| rd_data | output | 32 | Working copy of register `rd_idx` |
| wr_en | input | 1 | Register write strobe |
| wr_part | input | 1 | Write only bits 7:0 |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| st_valid | input | 1 | Store offered this cycle |
| st_addr | input | 16 | Store word address |
| st_data | input | 32 | Store data |
| st_stall | output | 1 | Buffer full, store not accepted |
| ld_addr | input | 16 | Load word address |
| ld_mem_data | input | 32 | Data memory returns for `ld_addr` |
| ld_data | output | 32 | Forwarded or memory load data |
| ld_hit | output | 1 | Load was served from the buffer |
| commit | input | 1 | End of block: checkpoint and release |
| rollback | input | 1 | Exception: restore and discard |
| mem_wr_en | output | 1 | Memory write strobe for a released store |
| mem_wr_addr | output | 16 | Memory write address |
| mem_wr_data | output | 32 | Memory write data |
| drain_busy | output | 1 | Released stores still draining |

## Verification
The read port, the load lookup and the memory write outputs are combinational views of state, so the bench changes inputs one nanosecond after a rising edge and reads these outputs after a short settle in the same cycle. Register writes, commit and rollback show up in the cycle after the edge that samples them, and the first released store appears in the cycle right after the commit edge, with one more per cycle after it. The bench therefore checks each drain write cycle by cycle against its own list of accepted stores and keeps a memory model that only the write port updates, so a store that leaks early, out of order or after a discard changes what it reads back. Register sweeps cover all sixteen registers with arithmetic patterns for full and partial writes.

// File: rtl/ckpt_pkg.sv
// Package: shared types of the speculative checkpoint block.
// Assumes: nothing beyond a standard SystemVerilog compiler.
package ckpt_pkg;

    // Action the store buffer takes on one clock edge.
    typedef enum logic [1:0] {
        SB_HOLD     = 2'd0,
        SB_RELEASE  = 2'd1,
        SB_DISCARD  = 2'd2
    } sb_ctl_e;

endpackage

// File: rtl/ckpt_regfile.sv
// Module: working/shadow register pair array.
// Holds NREG registers twice. Writes go to the working copy; commit copies
// working to shadow; rollback copies shadow back to working and wins over
// a write or commit in the same cycle. A partial write replaces only the
// low PART_W bits. Assumes NREG is at least 2 and PART_W < DW.
module ckpt_regfile #(
    parameter int NREG   = 16,
    parameter int DW     = 32,
    parameter int PART_W = 8,
    localparam int RW    = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_part,
    input  logic [RW-1:0]            wr_idx,
    input  logic [DW-1:0]            wr_data,
    input  logic [RW-1:0]            rd_idx,
    output logic [DW-1:0]            rd_data,
    input  logic                     commit,
    input  logic                     rollback,
    output logic [NREG-1:0][DW-1:0]  work_o,
    output logic [NREG-1:0][DW-1:0]  shadow_o
);

    logic [NREG-1:0][DW-1:0] work_q;
    logic [NREG-1:0][DW-1:0] shadow_q;
    logic [NREG-1:0]         wr_sel;
    logic [DW-1:0]           wr_merge;

    // Decode the write index into one select per register.
    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign wr_sel[g] = wr_en && (wr_idx == RW'(g));
    end

    // Build the value written: full word or new low byte over old upper bits.
    always_comb begin
        if (wr_part) begin
            wr_merge = {work_q[wr_idx][DW-1:PART_W], wr_data[PART_W-1:0]};
        end else begin
            wr_merge = wr_data;
        end
    end

    // Update working and shadow copies; rollback has the highest priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q   <= '0;
            shadow_q <= '0;
        end else if (rollback) begin
            work_q <= shadow_q;
        end else begin
            if (commit) begin
                shadow_q <= work_q;
            end
            for (int r = 0; r < NREG; r++) begin
                if (wr_sel[r]) begin
                    work_q[r] <= wr_merge;
                end
            end
        end
    end

    assign rd_data  = work_q[rd_idx];
    assign work_o   = work_q;
    assign shadow_o = shadow_q;

endmodule

// File: rtl/ckpt_storebuf.sv
// Module: gated store buffer with load forwarding and in-order drain.
// A ring of DEPTH entries. rel_q counts the oldest entries released by a
// commit; those drain to memory one per cycle. Rollback drops the rest.
// Loads search all held entries and take the youngest full-word match.
// Assumes DEPTH is a power of two and at least 2.
module ckpt_storebuf
    import ckpt_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           st_valid,
    input  logic [AW-1:0]  st_addr,
    input  logic [DW-1:0]  st_data,
    output logic           st_stall,
    input  logic [AW-1:0]  ld_addr,
    input  logic [DW-1:0]  ld_mem_data,
    output logic [DW-1:0]  ld_data,
    output logic           ld_hit,
    input  logic           commit,
    input  logic           rollback,
    output logic           mem_wr_en,
    output logic [AW-1:0]  mem_wr_addr,
    output logic [DW-1:0]  mem_wr_data,
    output logic           drain_busy,
    output logic [CW-1:0]  cnt_o,
    output logic [CW-1:0]  rel_o
);

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] head_q, tail_q, head_n, tail_n;
    logic [CW-1:0] cnt_q, rel_q, cnt_n, rel_n;
    logic          push, pop;
    logic [PW-1:0] slot;
    sb_ctl_e       ctl;

    assign st_stall = (cnt_q == CW'(DEPTH));
    assign pop      = (rel_q != '0);
    assign push     = st_valid && !st_stall && !rollback;

    // Choose the edge action; rollback dominates commit.
    always_comb begin
        if (rollback)    ctl = SB_DISCARD;
        else if (commit) ctl = SB_RELEASE;
        else             ctl = SB_HOLD;
    end

    // Compute next pointers and counts for the chosen action.
    always_comb begin
        head_n = head_q + PW'(pop);
        case (ctl)
            SB_DISCARD: begin
                tail_n = head_q + PW'(rel_q);
                cnt_n  = rel_q - CW'(pop);
                rel_n  = rel_q - CW'(pop);
            end
            SB_RELEASE: begin
                tail_n = tail_q + PW'(push);
                cnt_n  = cnt_q + CW'(push) - CW'(pop);
                rel_n  = cnt_q - CW'(pop);
            end
            default: begin
                tail_n = tail_q + PW'(push);
                cnt_n  = cnt_q + CW'(push) - CW'(pop);
                rel_n  = rel_q - CW'(pop);
            end
        endcase
    end

    // Register pointers and counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            rel_q  <= '0;
        end else begin
            head_q <= head_n;
            tail_q <= tail_n;
            cnt_q  <= cnt_n;
            rel_q  <= rel_n;
        end
    end

    // Write an accepted store into the tail slot.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[tail_q] <= st_addr;
            data_q[tail_q] <= st_data;
        end
    end

    // Search oldest to youngest so the youngest match overrides.
    always_comb begin
        ld_hit  = 1'b0;
        ld_data = ld_mem_data;
        slot    = head_q;
        for (int i = 0; i < DEPTH; i++) begin
            slot = head_q + PW'(i);
            if ((CW'(i) < cnt_q) && (addr_q[slot] == ld_addr)) begin
                ld_hit  = 1'b1;
                ld_data = data_q[slot];
            end
        end
    end

    assign mem_wr_en   = pop;
    assign mem_wr_addr = addr_q[head_q];
    assign mem_wr_data = data_q[head_q];
    assign drain_busy  = pop;
    assign cnt_o       = cnt_q;
    assign rel_o       = rel_q;

endmodule

// File: rtl/spec_ckpt_core.sv
// Module: top of the speculative checkpoint block.
// Joins the working/shadow register array and the gated store buffer under
// shared commit and rollback strobes. Assumes the engine raises commit or
// rollback for one cycle at a block boundary.
module spec_ckpt_core #(
    parameter int NREG     = 16,
    parameter int DW       = 32,
    parameter int AW       = 16,
    parameter int SB_DEPTH = 8,
    parameter int PART_W   = 8,
    localparam int RW      = $clog2(NREG),
    localparam int CW      = $clog2(SB_DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RW-1:0]  rd_idx,
    output logic [DW-1:0]  rd_data,
    input  logic           wr_en,
    input  logic           wr_part,
    input  logic [RW-1:0]  wr_idx,
    input  logic [DW-1:0]  wr_data,
    input  logic           st_valid,
    input  logic [AW-1:0]  st_addr,
    input  logic [DW-1:0]  st_data,
    output logic           st_stall,
    input  logic [AW-1:0]  ld_addr,
    input  logic [DW-1:0]  ld_mem_data,
    output logic [DW-1:0]  ld_data,
    output logic           ld_hit,
    input  logic           commit,
    input  logic           rollback,
    output logic           mem_wr_en,
    output logic [AW-1:0]  mem_wr_addr,
    output logic [DW-1:0]  mem_wr_data,
    output logic           drain_busy
);

    logic [NREG-1:0][DW-1:0] work_q;
    logic [NREG-1:0][DW-1:0] shadow_q;
    logic [CW-1:0]           sb_cnt;
    logic [CW-1:0]           sb_rel;

    ckpt_regfile #(
        .NREG   (NREG),
        .DW     (DW),
        .PART_W (PART_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_part  (wr_part),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .commit   (commit),
        .rollback (rollback),
        .work_o   (work_q),
        .shadow_o (shadow_q)
    );

    ckpt_storebuf #(
        .DEPTH (SB_DEPTH),
        .AW    (AW),
        .DW    (DW)
    ) u_sbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .st_valid    (st_valid),
        .st_addr     (st_addr),
        .st_data     (st_data),
        .st_stall    (st_stall),
        .ld_addr     (ld_addr),
        .ld_mem_data (ld_mem_data),
        .ld_data     (ld_data),
        .ld_hit      (ld_hit),
        .commit      (commit),
        .rollback    (rollback),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .drain_busy  (drain_busy),
        .cnt_o       (sb_cnt),
        .rel_o       (sb_rel)
    );

endmodule

// File: rtl/ckpt_checker.sv
// Module: property checker for spec_ckpt_core, attached by bind.
// Assumes it sees the register arrays and buffer counts of the top.
module ckpt_checker #(
    parameter int NREG     = 16,
    parameter int DW       = 32,
    parameter int SB_DEPTH = 8,
    localparam int CW      = $clog2(SB_DEPTH + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    commit,
    input logic                    rollback,
    input logic                    st_valid,
    input logic                    st_stall,
    input logic [NREG-1:0][DW-1:0] work_q,
    input logic [NREG-1:0][DW-1:0] shadow_q,
    input logic [CW-1:0]           sb_cnt,
    input logic [CW-1:0]           sb_rel
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sb_cnt == '0 && sb_rel == '0 && work_q == '0 && shadow_q == '0));

    // R3
    commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !rollback) |=> shadow_q == $past(work_q));

    // R4
    rollback_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> work_q == $past(shadow_q));

    // R5
    release_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sb_rel != '0) |-> $past(commit));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sb_cnt <= CW'(SB_DEPTH));

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_stall && st_valid && !commit && !rollback && sb_rel == '0)
        |=> sb_cnt == $past(sb_cnt));

    // R10
    rollback_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> sb_cnt == sb_rel);

endmodule

bind spec_ckpt_core ckpt_checker #(
    .NREG     (NREG),
    .DW       (DW),
    .SB_DEPTH (SB_DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .rollback (rollback),
    .st_valid (st_valid),
    .st_stall (st_stall),
    .work_q   (work_q),
    .shadow_q (shadow_q),
    .sb_cnt   (sb_cnt),
    .sb_rel   (sb_rel)
);

// File: tb/sim_spec_ckpt_core.sv
// Bench: directed sweeps over registers and store buffer of spec_ckpt_core.
module sim_spec_ckpt_core;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rd_idx;
    logic [31:0] rd_data;
    logic        wr_en, wr_part;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;
    logic        st_valid;
    logic [15:0] st_addr;
    logic [31:0] st_data;
    logic        st_stall;
    logic [15:0] ld_addr;
    logic [31:0] ld_mem_data;
    logic [31:0] ld_data;
    logic        ld_hit;
    logic        commit, rollback;
    logic        mem_wr_en;
    logic [15:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        drain_busy;

    logic [31:0] mem [64];
    int          n_writes = 0;
    int          n_checks = 0;
    int          n_errors = 0;

    always #5 clk = ~clk;

    spec_ckpt_core u0 (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_part(wr_part), .wr_idx(wr_idx), .wr_data(wr_data),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_stall(st_stall),
        .ld_addr(ld_addr), .ld_mem_data(ld_mem_data), .ld_data(ld_data), .ld_hit(ld_hit),
        .commit(commit), .rollback(rollback), .mem_wr_en(mem_wr_en),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .drain_busy(drain_busy)
    );

    // Memory model: only the write port changes it.
    assign ld_mem_data = mem[ld_addr[5:0]];
    always @(posedge clk) begin
        if (rst_n && mem_wr_en) begin
            mem[mem_wr_addr[5:0]] <= mem_wr_data;
            n_writes <= n_writes + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_in();
        wr_en = 0; wr_part = 0; st_valid = 0; commit = 0; rollback = 0;
    endtask

    function automatic logic [31:0] full_pat(input int r);
        return 32'hA500_0000 ^ (32'(r) * 32'h0101_0101) ^ 32'(r << 4);
    endfunction

    function automatic logic [31:0] part_pat(input int r);
        return {full_pat(r)[31:8], 8'(r + 8'h30)};
    endfunction

    task automatic wreg(input int r, input logic [31:0] d, input logic part);
        wr_en = 1; wr_part = part; wr_idx = 4'(r); wr_data = d;
        cyc();
        clear_in();
    endtask

    task automatic store(input logic [15:0] a, input logic [31:0] d);
        st_valid = 1; st_addr = a; st_data = d;
        cyc();
        clear_in();
    endtask

    task automatic check_regs(input string req, input int kind);
        for (int r = 0; r < 16; r++) begin
            logic [31:0] e;
            rd_idx = 4'(r);
            #1;
            e = (kind == 0) ? 32'h0 : (kind == 1) ? full_pat(r) : part_pat(r);
            check(req, rd_data, e);
        end
    endtask

    // Watchdog: a hung run ends as a failure with the summary line.
    initial begin
        #1000000;
        n_errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int w0;
        for (int i = 0; i < 64; i++) mem[i] = 32'h1000_0000 + 32'(i);
        rst_n = 0; clear_in();
        rd_idx = 0; wr_idx = 0; wr_data = 0; st_addr = 0; st_data = 0; ld_addr = 0;
        repeat (3) cyc();
        rst_n = 1;
        cyc();

        // R1: reset state
        check_regs("R1 reg after reset", 0);
        check("R1 stall", 32'(st_stall), 0);
        check("R1 busy", 32'(drain_busy), 0);
        check("R1 mem_wr_en", 32'(mem_wr_en), 0);

        // R2: full writes then partial byte writes over all registers
        for (int r = 0; r < 16; r++) wreg(r, full_pat(r), 0);
        check_regs("R2 full write", 1);
        for (int r = 0; r < 16; r++) wreg(r, 32'hFFFF_FF00 | 32'(r + 8'h30), 1);
        check_regs("R2 partial write", 2);

        // R4: rollback with nothing committed returns all to zero
        rollback = 1; cyc(); clear_in();
        check_regs("R4 rollback to reset state", 0);

        // R3: commit full values, overwrite partially, roll back
        for (int r = 0; r < 16; r++) wreg(r, full_pat(r), 0);
        commit = 1; cyc(); clear_in();
        for (int r = 0; r < 16; r++) wreg(r, 32'hFFFF_FF00 | 32'(r + 8'h30), 1);
        check_regs("R3 speculative partial", 2);
        rollback = 1; cyc(); clear_in();
        check_regs("R3 committed values restored", 1);

        // R3: write in commit cycle is not checkpointed
        wr_en = 1; wr_idx = 3; wr_data = 32'hDEAD_0003; commit = 1;
        cyc(); clear_in();
        rd_idx = 3; #1;
        check("R3 write with commit visible", rd_data, 32'hDEAD_0003);
        rollback = 1; cyc(); clear_in();
        rd_idx = 3; #1;
        check("R3 write with commit not in shadow", rd_data, full_pat(3));

        // R4: rollback beats same-cycle write and commit
        wr_en = 1; wr_idx = 5; wr_data = 32'hBEEF_0005; rollback = 1; commit = 1;
        cyc(); clear_in();
        rd_idx = 5; #1;
        check("R4 rollback wins over write", rd_data, full_pat(5));
        rollback = 1; cyc(); clear_in();
        rd_idx = 5; #1;
        check("R4 commit ignored under rollback", rd_data, full_pat(5));

        // R5/R6: buffered stores held and forwarded
        w0 = n_writes;
        store(16'd4, 32'h0000_D001);
        store(16'd9, 32'h0000_D002);
        store(16'd4, 32'h0000_D003);
        ld_addr = 16'd4; #1;
        check("R6 youngest hit", ld_data, 32'h0000_D003);
        check("R6 hit flag", 32'(ld_hit), 1);
        ld_addr = 16'd9; #1;
        check("R6 older entry hit", ld_data, 32'h0000_D002);
        ld_addr = 16'd12; #1;
        check("R6 miss returns memory", ld_data, 32'h1000_000C);
        check("R6 miss flag", 32'(ld_hit), 0);
        repeat (3) begin
            check("R5 no write before commit", 32'(mem_wr_en), 0);
            cyc();
        end
        check("R5 memory untouched", 32'(n_writes - w0), 0);

        // R7/R8: commit drains in order, one per cycle
        commit = 1; cyc(); clear_in();
        check("R7 drain 0 en", 32'(mem_wr_en), 1);
        check("R7 drain 0 addr", 32'(mem_wr_addr), 4);
        check("R7 drain 0 data", mem_wr_data, 32'h0000_D001);
        check("R8 busy 0", 32'(drain_busy), 1);
        cyc();
        check("R7 drain 1 addr", 32'(mem_wr_addr), 9);
        check("R7 drain 1 data", mem_wr_data, 32'h0000_D002);
        cyc();
        check("R7 drain 2 addr", 32'(mem_wr_addr), 4);
        check("R7 drain 2 data", mem_wr_data, 32'h0000_D003);
        check("R8 busy 2", 32'(drain_busy), 1);
        cyc();
        check("R8 busy low after drain", 32'(drain_busy), 0);
        check("R7 final memory 4", mem[4], 32'h0000_D003);
        check("R7 final memory 9", mem[9], 32'h0000_D002);

        // R9: fill the buffer, offer one more
        w0 = n_writes;
        for (int i = 0; i < 8; i++) store(16'(20 + i), 32'hC000_0000 + 32'(i));
        check("R9 stall when full", 32'(st_stall), 1);
        store(16'd40, 32'hBAD0_0040);
        ld_addr = 16'd40; #1;
        check("R9 dropped store not forwarded", 32'(ld_hit), 0);
        commit = 1; cyc(); clear_in();
        begin
            int busy_cyc = 0;
            for (int i = 0; i < 8; i++) begin
                if (drain_busy) busy_cyc++;
                check("R7 full drain addr", 32'(mem_wr_addr), 32'(20 + i));
                cyc();
            end
            check("R8 busy cycle count", 32'(busy_cyc), 8);
        end
        check("R8 busy low", 32'(drain_busy), 0);
        check("R9 eight writes only", 32'(n_writes - w0), 8);
        check("R9 dropped store not in memory", mem[40], 32'h1000_0028);

        // R10: rollback discards unreleased stores, same-cycle store too
        w0 = n_writes;
        store(16'd50, 32'hE000_0050);
        store(16'd51, 32'hE000_0051);
        st_valid = 1; st_addr = 16'd52; st_data = 32'hE000_0052; rollback = 1;
        cyc(); clear_in();
        ld_addr = 16'd50; #1;
        check("R10 discarded 50", ld_data, 32'h1000_0032);
        ld_addr = 16'd52; #1;
        check("R10 same-cycle store dropped", 32'(ld_hit), 0);
        repeat (3) cyc();
        check("R10 no writes after discard", 32'(n_writes - w0), 0);

        // R10: released stores survive a later rollback
        store(16'd56, 32'hF000_0056);
        store(16'd57, 32'hF000_0057);
        commit = 1; cyc(); clear_in();
        rollback = 1; cyc(); clear_in();
        repeat (3) cyc();
        check("R10 released 56 drained", mem[56], 32'hF000_0056);
        check("R10 released 57 drained", mem[57], 32'hF000_0057);

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule